// File: doc/BRIEF.md
# Adaptive Pipeline Depth Controller

This block decides how many pipelined sub-schedulers of a switch scheduler are switched on. Every clock cycle is one time slot. In each slot the block takes the number of packets that arrived in that slot. It keeps the mean arrivals per slot over the last `W` slots and compares that mean with an upper and a lower threshold. Both thresholds depend on the present depth `k`. When one comparison holds for `PERSIST` slots in a row, `k` moves by one.

The block drives three outputs from `k`. A thermometer vector enables sub-schedulers 1 to `k`. A binary delay-stage select sets the added input delay to exactly `k` slots. Stage `i` of that delay line inserts `2^i` slots when its bit is set. A downstream delay line built from `$clog2(K)+1` such stages therefore needs no decoding.

Control is a three-state machine:
- **HOLD**: no condition is pending.
- **RISE**: the upper condition holds and is being counted.
- **FALL**: the lower condition holds and is being counted.

The transitions are:
- **HOLD→RISE** on the first slot of the upper condition.
- **HOLD→FALL** on the first slot of the lower condition.
- **RISE→RISE** and **FALL→FALL** while the run continues.
- **RISE→HOLD** and **FALL→HOLD** when the run breaks, or when the run completes and the depth step is taken.
- **RISE→FALL** and **FALL→RISE** when the opposite condition starts in the slot that breaks a run.

Top module: `adaptive_depth_ctrl`

## Requirements
- R1: After reset the depth is 1, the enable vector is 0001, the delay select is 1 and the load estimate is 0.
- R2: After each slot, `load_est` equals floor(sum of the last `W` arrival counts / `W`). Counts from before the window, and slots before reset, count as 0.
- R3: Suppose the estimate seen at `PERSIST` consecutive clock edges is greater than `STEP*k` and `k < K`. Then `k` rises by one at the last of those edges.
- R4: Suppose the estimate seen at `PERSIST` consecutive edges is less than `STEP*(k-1) - HYST` and `k > 1`. Then `k` falls by one at the last of those edges.
- R5: A slot in which the pending condition does not hold restarts its run. A run shorter than `PERSIST` slots leaves `k` unchanged.
- R6: After each change of `k` the run count restarts against the new thresholds. Two changes of `k` are therefore at least `PERSIST` slots apart.
- R7: `k` stays within 1 and `K` under any input.
- R8: Enable bit `i` (sub-scheduler `i+1`) is high exactly when `i < k`.
- R9: The delay select, `$clog2(K)+1` bits wide, is the unsigned binary code of `k`. Bit `i` weighs `2^i` slots.
- R10: `k` changes by at most one per slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slot clock, one edge per slot |
| rst_n | input | 1 | Active-low synchronous reset |
| arr_cnt | input | $clog2(NPORT+1) | Packet arrivals in the current slot |
| load_est | output | $clog2(NPORT+1) | Windowed mean arrivals per slot |
| depth | output | $clog2(K+1) | Active sub-scheduler count k |
| sub_en | output | K | Thermometer enables, bit 0 = first sub-scheduler |
| dly_sel | output | $clog2(K)+1 | Binary-weighted delay-stage select |

## Verification
The stimulus first holds constant arrival levels for long runs. Full load must climb one step at a time to the ceiling, and idle must fall to the floor, which separates the bounds from the step logic.

Three further patterns target the estimator and the run counter:
- A short burst of four heavy slots lifts the estimate above the threshold for only two slots. Depth must stay put, which distinguishes a true consecutive-run count from a cumulative one.
- An alternating full/empty pattern keeps the windowed mean flat even though each slot jumps sharply.
- A sweep over every ordered pair of levels, six slots each, crosses every threshold from both sides.

An arithmetic model in the bench follows each slot. It checks the estimate, the depth, the enables and the delay code.

// File: rtl/adc_pkg.sv
package adc_pkg;

    typedef enum logic [1:0] {
        ST_HOLD = 2'd0,
        ST_RISE = 2'd1,
        ST_FALL = 2'd2
    } dstate_e;

endpackage

// File: rtl/adc_load_window.sv
module adc_load_window #(
    parameter int NPORT = 8,
    parameter int W     = 8
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [$clog2(NPORT+1)-1:0]        arr_cnt,
    output logic [$clog2(NPORT+1)-1:0]        est
);
    localparam int CNT_W = $clog2(NPORT + 1);
    localparam int LOG2W = $clog2(W);
    localparam int SUM_W = CNT_W + LOG2W;

    logic [CNT_W-1:0] hist_q [W];
    logic [LOG2W-1:0] ptr_q;
    logic [SUM_W-1:0] sum_q;

    // Circular history: the slot being overwritten is the one leaving the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            sum_q <= '0;
            for (int i = 0; i < W; i++) hist_q[i] <= '0;
        end else begin
            hist_q[ptr_q] <= arr_cnt;
            ptr_q         <= ptr_q + LOG2W'(1);
            sum_q         <= sum_q + SUM_W'(arr_cnt) - SUM_W'(hist_q[ptr_q]);
        end
    end

    // W is a power of two, so the mean is a plain shift.
    assign est = sum_q[SUM_W-1:LOG2W];

    // R2
    sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(sum_q) <= W * NPORT);

endmodule

// File: rtl/adc_depth_fsm.sv
module adc_depth_fsm
    import adc_pkg::*;
#(
    parameter int K       = 4,
    parameter int STEP    = 2,
    parameter int HYST    = 1,
    parameter int PERSIST = 3,
    parameter int CNT_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [CNT_W-1:0]         est,
    output logic [$clog2(K+1)-1:0]   depth
);
    localparam int K_W = $clog2(K + 1);
    localparam int P_W = $clog2(PERSIST + 1);

    dstate_e        state_q, state_d;
    logic [P_W-1:0] pcnt_q, pcnt_d;
    logic [K_W-1:0] depth_q, depth_d;
    logic           up_c, dn_c;
    int             run_up, run_dn;

    assign up_c = (int'(depth_q) < K) && (int'(est) > STEP * int'(depth_q));
    assign dn_c = (int'(depth_q) > 1) &&
                  (int'(est) < STEP * (int'(depth_q) - 1) - HYST);

    always_comb begin
        state_d = state_q;
        pcnt_d  = pcnt_q;
        depth_d = depth_q;
        run_up  = 1;
        run_dn  = 1;
        unique case (state_q)
            ST_HOLD: begin
                run_up = 1;
                run_dn = 1;
            end
            ST_RISE: begin
                run_up = int'(pcnt_q) + 1;
                run_dn = 1;
            end
            ST_FALL: begin
                run_up = 1;
                run_dn = int'(pcnt_q) + 1;
            end
            default: begin
                run_up = 1;
                run_dn = 1;
            end
        endcase
        if (up_c) begin
            if (run_up >= PERSIST) begin
                depth_d = depth_q + K_W'(1);
                state_d = ST_HOLD;
                pcnt_d  = '0;
            end else begin
                state_d = ST_RISE;
                pcnt_d  = P_W'(run_up);
            end
        end else if (dn_c) begin
            if (run_dn >= PERSIST) begin
                depth_d = depth_q - K_W'(1);
                state_d = ST_HOLD;
                pcnt_d  = '0;
            end else begin
                state_d = ST_FALL;
                pcnt_d  = P_W'(run_dn);
            end
        end else begin
            state_d = ST_HOLD;
            pcnt_d  = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HOLD;
            pcnt_q  <= '0;
            depth_q <= K_W'(1);
        end else begin
            state_q <= state_d;
            pcnt_q  <= pcnt_d;
            depth_q <= depth_d;
        end
    end

    assign depth = depth_q;

    // R7
    depth_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(depth_q) >= 1 && int'(depth_q) <= K);

    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q != $past(depth_q) |->
            (int'(depth_q) == int'($past(depth_q)) + 1) ||
            (int'(depth_q) + 1 == int'($past(depth_q))));

    // R6
    persist_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q != $past(depth_q) |-> int'($past(pcnt_q)) == PERSIST - 1);

    // R3
    rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q > $past(depth_q) |-> $past(up_c));

    // R4
    fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        depth_q < $past(depth_q) |-> $past(dn_c));

    // R5
    run_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(pcnt_q) < PERSIST);

endmodule

// File: rtl/adc_stage_decode.sv
module adc_stage_decode #(
    parameter int K = 4
) (
    input  logic [$clog2(K+1)-1:0] depth,
    output logic [K-1:0]           sub_en,
    output logic [$clog2(K):0]     dly_sel
);
    localparam int DSW = $clog2(K) + 1;

    // One enable per sub-scheduler, thermometer coded from the depth.
    for (genvar i = 0; i < K; i++) begin : g_en
        always_comb sub_en[i] = (int'(depth) > i);
    end

    // Stage i inserts 2^i slots, so the select is the binary depth itself.
    always_comb dly_sel = DSW'(depth);

endmodule

// File: rtl/adaptive_depth_ctrl.sv
module adaptive_depth_ctrl #(
    parameter int NPORT   = 8,
    parameter int K       = 4,
    parameter int W       = 8,
    parameter int STEP    = 2,
    parameter int HYST    = 1,
    parameter int PERSIST = 3
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(NPORT+1)-1:0]   arr_cnt,
    output logic [$clog2(NPORT+1)-1:0]   load_est,
    output logic [$clog2(K+1)-1:0]       depth,
    output logic [K-1:0]                 sub_en,
    output logic [$clog2(K):0]           dly_sel
);
    localparam int CNT_W = $clog2(NPORT + 1);

    adc_load_window #(.NPORT(NPORT), .W(W)) u_win (
        .clk     (clk),
        .rst_n   (rst_n),
        .arr_cnt (arr_cnt),
        .est     (load_est)
    );

    adc_depth_fsm #(
        .K(K), .STEP(STEP), .HYST(HYST), .PERSIST(PERSIST), .CNT_W(CNT_W)
    ) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .est   (load_est),
        .depth (depth)
    );

    adc_stage_decode #(.K(K)) u_dec (
        .depth   (depth),
        .sub_en  (sub_en),
        .dly_sel (dly_sel)
    );

    // R8
    en_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sub_en[0] && ($countones(sub_en) == int'(depth)));

    // R9
    dly_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sub_en) == int'(dly_sel));

endmodule

// File: tb/tb_adaptive_depth_ctrl.sv
module tb_adaptive_depth_ctrl;
    localparam int CLK_P   = 10;
    localparam int NPORT   = 8;
    localparam int K       = 4;
    localparam int W       = 8;
    localparam int STEP    = 2;
    localparam int HYST    = 1;
    localparam int PERSIST = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] arr_cnt = '0;
    logic [3:0] load_est;
    logic [2:0] depth;
    logic [3:0] sub_en;
    logic [2:0] dly_sel;

    int checks = 0;
    int errors = 0;
    int m_hist [W];
    int m_ptr = 0, m_sum = 0, m_k = 1, m_st = 0, m_cnt = 0;
    int prev_depth = 1, since_chg = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    adaptive_depth_ctrl #(
        .NPORT(NPORT), .K(K), .W(W), .STEP(STEP), .HYST(HYST), .PERSIST(PERSIST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .arr_cnt(arr_cnt),
        .load_est(load_est), .depth(depth), .sub_en(sub_en), .dly_sel(dly_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One slot: drive, let the edge pass, advance the model, compare.
    task automatic slot(input int a);
        int est_old, n, moved;
        bit up, dn;
        @(negedge clk);
        arr_cnt = 4'(a);
        @(posedge clk);
        #1;
        est_old = m_sum / W;
        up = (m_k < K) && (est_old > STEP * m_k);
        dn = (m_k > 1) && (est_old < STEP * (m_k - 1) - HYST);
        moved = 0;
        if (up) begin
            n = (m_st == 1) ? m_cnt + 1 : 1;
            if (n >= PERSIST) begin m_k++; m_st = 0; m_cnt = 0; moved = 1; end
            else begin m_st = 1; m_cnt = n; end
        end else if (dn) begin
            n = (m_st == 2) ? m_cnt + 1 : 1;
            if (n >= PERSIST) begin m_k--; m_st = 0; m_cnt = 0; moved = -1; end
            else begin m_st = 2; m_cnt = n; end
        end else begin
            m_st = 0; m_cnt = 0;
        end
        m_sum = m_sum + a - m_hist[m_ptr];
        m_hist[m_ptr] = a;
        m_ptr = (m_ptr + 1) % W;

        chk(int'(load_est) == m_sum / W, "R2 estimate", int'(load_est), m_sum / W);
        if (moved == 1)
            chk(int'(depth) == m_k, "R3 depth rise", int'(depth), m_k);
        else if (moved == -1)
            chk(int'(depth) == m_k, "R4 depth fall", int'(depth), m_k);
        else
            chk(int'(depth) == m_k, "R5 depth held", int'(depth), m_k);
        chk(int'(sub_en) == (1 << m_k) - 1, "R8 enables", int'(sub_en), (1 << m_k) - 1);
        chk(int'(dly_sel) == m_k, "R9 delay code", int'(dly_sel), m_k);

        since_chg++;
        if (int'(depth) != prev_depth) begin
            chk(int'(depth) == prev_depth + 1 || int'(depth) == prev_depth - 1,
                "R10 step size", int'(depth), prev_depth);
            chk(since_chg >= PERSIST, "R6 change spacing", since_chg, PERSIST);
            since_chg = 0;
        end
        chk(int'(depth) >= 1 && int'(depth) <= K, "R7 range", int'(depth), m_k);
        prev_depth = int'(depth);
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < W; i++) m_hist[i] = 0;
        repeat (3) @(posedge clk);
        #1;
        chk(int'(depth) == 1, "R1 reset depth", int'(depth), 1);
        chk(int'(sub_en) == 1, "R1 reset enables", int'(sub_en), 1);
        chk(int'(dly_sel) == 1, "R1 reset delay code", int'(dly_sel), 1);
        chk(int'(load_est) == 0, "R1 reset estimate", int'(load_est), 0);
        @(negedge clk);
        rst_n = 1'b1;

        repeat (10) slot(0);
        // full load climbs to the ceiling and stays there
        repeat (50) slot(8);
        chk(int'(depth) == K, "R7 ceiling", int'(depth), K);
        // idle sinks to the floor
        repeat (60) slot(0);
        chk(int'(depth) == 1, "R7 floor", int'(depth), 1);
        // moderate load settles at two
        repeat (30) slot(3);
        chk(int'(depth) == 2, "R3 settle at two", int'(depth), 2);
        // short burst: over threshold for two slots only
        repeat (4) slot(8);
        repeat (2) slot(0);
        repeat (2) slot(3);
        chk(int'(depth) == 2, "R5 short burst ignored", int'(depth), 2);
        repeat (40) slot(0);
        chk(int'(depth) == 1, "R4 drain to one", int'(depth), 1);
        // every ordered pair of levels
        for (int l1 = 0; l1 <= NPORT; l1++)
            for (int l2 = 0; l2 <= NPORT; l2++) begin
                repeat (6) slot(l1);
                repeat (6) slot(l2);
            end
        // flat mean from a jittery input
        for (int j = 0; j < 40; j++) slot((j % 2 == 0) ? 8 : 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule